// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block sequences the bulk erase of a flash array that is split into equal 32 KB blocks (the array has 4, 6 or 8 of them). Erase is a whole-block operation that can only turn stored zeros into ones. Turning a one back into a zero takes a separate program operation. The analog high-voltage path and the cells are not modelled. The erase pulse is a counter, and a register with one bit per block stands for "this block reads erased".

Software drives two 16-bit control registers through a simple write port. It first clears the protect bit and loads the pulse timing. It then writes the block-select mask with erase mode and setup enabled, and performs an interlock write to any array address. Only after that does it set the enable bit. The sequencer raises a high-voltage status bit for a timed pulse of (prescale+1)*(count+1) cycles. Software polls the status bit until it reads zero, then clears the enable bit. Any other ordering is rejected and reported through an error flag. Which selected blocks actually receive voltage depends on three things: the protect bit, a global erase enable input, and a separate enable input for block 0.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, the status register reads 16'h0100 (protect set, all other fields 0). The high-voltage status is 0, the error flag is 0, the erased mask is all zeros and the timing register reads 0.
- R2: Timing register (reg_sel=0): bits [7:0] hold the prescale and bits [15:8] hold the pulse count. Status register (reg_sel=1): bits [7:0] hold the block select, bit 8 is protect, bit 9 is erase mode, bit 10 is setup and bit 11 is the high-voltage enable. An interlock strobe is accepted only while idle with protect=0, erase mode=1 and setup=1. A write that sets the enable without an accepted interlock stores nothing, starts no pulse and sets the error flag. The next accepted interlock clears the error flag.
- R3: The high-voltage status rises one cycle after the enable bit is stored. It stays high for exactly (prescale+1)*(count+1) cycles and then falls.
- R4: When a pulse completes, every permitted selected block is set in the erased mask. Bits that are already set stay set.
- R5: With the global erase enable input at 0 during the enable write, no block is marked, although the pulse still runs.
- R6: With the block-0 enable input at 0 during the enable write, block 0 is not marked even when it is selected. The other blocks are unaffected.
- R7: While the enable bit is 1, writes to the timing register and to the select, protect, mode and setup fields are ignored.
- R8: A status-register write with bit 11 = 0 while the enable is 1 clears only the enable and returns the sequencer to idle. A later enable needs a new interlock.
- R9: Clearing the enable during a pulse ends the pulse at once: the status is 0 from the next cycle on, and nothing is marked.
- R10: A program strobe clears the given bits of the erased mask while the enable is 0. While the enable is 1 it is ignored.
- R11: Select bits at positions NUM_BLOCKS and above have no effect on the erased mask.
- R12: A status-register field write (bit 11 = 0) after an accepted interlock disarms the sequence. A following enable write is then rejected as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = timing register, 1 = status register |
| reg_wdata | input | 16 | Register write data |
| array_wr | input | 1 | Interlock write strobe to any array location |
| erase_en_global | input | 1 | Global erase voltage enable |
| blk0_en | input | 1 | Voltage enable for block 0 |
| prog_wr | input | 1 | Program strobe |
| prog_blocks | input | NUM_BLOCKS | Blocks whose erased bit the program strobe clears |
| timing_rd | output | 16 | Timing register readback |
| status_rd | output | 16 | Status register readback, enable at bit 11 |
| hv_status | output | 1 | High-voltage pulse active |
| seq_err | output | 1 | Ordering error flag |
| erased_mask | output | NUM_BLOCKS | Per-block erased state |

## Verification
The assertions check several properties on every cycle. The high-voltage status never shows without the enable, and it only rises out of the start state. The error flag only rises after a rejected enable write. Locked fields stay stable while the enable is 1. The erased mask only gains bits at a pulse end and only loses them while the enable is 0. The gate registers are cleared whenever the global or block-0 enable was off at the start. The exact pulse length and the per-block result of each gating combination are shown only by the bench scenarios, which compute them from the programmed fields. The same holds for abort, re-arm and disarm orderings and for ignoring out-of-range select bits.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 8;
  localparam int PROT_BIT  = 8;
  localparam int MODE_BIT  = 9;
  localparam int SETUP_BIT = 10;
  localparam int EN_BIT    = 11;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_START = 3'd2,
    ST_PULSE = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/ers_regs.sv
module ers_regs
  import erase_seq_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ehv_q,
  output logic [PRE_W-1:0]  pre_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              prot_q,
  output logic              mode_q,
  output logic              setup_q,
  output logic              field_wr,
  output logic              en_set_req,
  output logic              en_clr_req,
  output logic [DATA_W-1:0] timing_rd
);
  localparam int TIM_W = PRE_W + CNT_W;

  logic wr_stat;
  logic wr_tim;

  assign wr_stat    = reg_wr & reg_sel;
  assign wr_tim     = reg_wr & ~reg_sel & ~ehv_q;
  assign en_set_req = wr_stat &  reg_wdata[EN_BIT] & ~ehv_q;
  assign en_clr_req = wr_stat & ~reg_wdata[EN_BIT] &  ehv_q;
  assign field_wr   = wr_stat & ~reg_wdata[EN_BIT] & ~ehv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (wr_tim) begin
      pre_q <= reg_wdata[PRE_W-1:0];
      cnt_q <= reg_wdata[PRE_W +: CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      prot_q  <= 1'b1;
      mode_q  <= 1'b0;
      setup_q <= 1'b0;
    end else if (field_wr) begin
      sel_q   <= reg_wdata[SEL_W-1:0];
      prot_q  <= reg_wdata[PROT_BIT];
      mode_q  <= reg_wdata[MODE_BIT];
      setup_q <= reg_wdata[SETUP_BIT];
    end
  end

  assign timing_rd = DATA_W'({cnt_q, pre_q});

  // R7
  field_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ehv_q |=> ($stable(sel_q) && $stable(prot_q) && $stable(mode_q) &&
               $stable(setup_q) && $stable(pre_q) && $stable(cnt_q)));

  initial begin
    tim_width_chk: assert (TIM_W <= DATA_W);
  end
endmodule

// File: rtl/ers_timer.sv
module ers_timer #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_in,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             last
);
  logic [PRE_W-1:0] pre_c;
  logic [CNT_W-1:0] cnt_c;

  assign last = (pre_c == '0) && (cnt_c == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_c <= '0;
      cnt_c <= '0;
    end else if (load) begin
      pre_c <= pre_in;
      cnt_c <= cnt_in;
    end else if (run && !last) begin
      if (pre_c == '0) begin
        pre_c <= pre_in;
        cnt_c <= cnt_c - 1'b1;
      end else begin
        pre_c <= pre_c - 1'b1;
      end
    end
  end

  // R3
  timer_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && !last && $past(run)) |-> !($past(last)));
endmodule

// File: rtl/ers_fsm.sv
module ers_fsm
  import erase_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       array_wr,
  input  logic       field_wr,
  input  logic       en_set_req,
  input  logic       en_clr_req,
  input  logic       prot_q,
  input  logic       mode_q,
  input  logic       setup_q,
  input  logic       last,
  output seq_state_t state,
  output logic       ehv_q,
  output logic       hv_q,
  output logic       err_q,
  output logic       start,
  output logic       run,
  output logic       mark
);
  logic ilk_ok;

  assign ilk_ok = array_wr & ~prot_q & mode_q & setup_q;
  assign ehv_q  = (state == ST_START) || (state == ST_PULSE) || (state == ST_DONE);
  assign start  = (state == ST_START);
  assign run    = (state == ST_PULSE);
  assign mark   = (state == ST_PULSE) && last && !en_clr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      hv_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (en_set_req) err_q <= 1'b1;
          if (ilk_ok) begin
            state <= ST_ARMED;
            err_q <= 1'b0;
          end
        end
        ST_ARMED: begin
          if (en_set_req)    state <= ST_START;
          else if (field_wr) state <= ST_IDLE;
        end
        ST_START: begin
          if (en_clr_req) state <= ST_IDLE;
          else begin
            state <= ST_PULSE;
            hv_q  <= 1'b1;
          end
        end
        ST_PULSE: begin
          if (en_clr_req) begin
            state <= ST_IDLE;
            hv_q  <= 1'b0;
          end else if (last) begin
            state <= ST_DONE;
            hv_q  <= 1'b0;
          end
        end
        ST_DONE: begin
          if (en_clr_req) state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
          hv_q  <= 1'b0;
        end
      endcase
    end
  end

  // R3
  hv_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    hv_q |-> ehv_q);

  // R3
  hv_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_q) |-> $past(state == ST_START));

  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(en_set_req && state != ST_ARMED));

  // R8
  arm_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && $past(state) != ST_ARMED) |-> $past(array_wr));
endmodule

// File: rtl/ers_blockmap.sv
module ers_blockmap
  import erase_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  latch,
  input  logic                  mark,
  input  logic                  busy,
  input  logic [SEL_W-1:0]      sel_q,
  input  logic                  prot_q,
  input  logic                  mode_q,
  input  logic                  gen_en,
  input  logic                  blk0_en,
  input  logic                  prog_wr,
  input  logic [NUM_BLOCKS-1:0] prog_blocks,
  output logic [NUM_BLOCKS-1:0] erased_q
);
  logic [NUM_BLOCKS-1:0] permit;
  logic [NUM_BLOCKS-1:0] eff_q;

  generate
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_permit
      if (b == 0) begin : g_b0
        assign permit[b] = sel_q[b] & blk0_en & gen_en & ~prot_q & mode_q;
      end else begin : g_bn
        assign permit[b] = sel_q[b] & gen_en & ~prot_q & mode_q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        eff_q <= '0;
    else if (latch) eff_q <= permit;
  end

  always_ff @(posedge clk) begin
    if (rst)                   erased_q <= '0;
    else if (mark)             erased_q <= erased_q | eff_q;
    else if (prog_wr && !busy) erased_q <= erased_q & ~prog_blocks;
  end

  // R4
  mark_only_chk: assert property (@(posedge clk) disable iff (rst)
    ((erased_q & ~$past(erased_q)) != '0) |-> $past(mark));

  // R10
  prog_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((~erased_q & $past(erased_q)) != '0) |-> $past(!busy && prog_wr));

  // R5
  gen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $past(latch && !gen_en) |-> (eff_q == '0));

  // R6
  blk0_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $past(latch && !blk0_en) |-> !eff_q[0]);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int PRE_W      = 8,
  parameter int CNT_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_sel,
  input  logic [15:0]           reg_wdata,
  input  logic                  array_wr,
  input  logic                  erase_en_global,
  input  logic                  blk0_en,
  input  logic                  prog_wr,
  input  logic [NUM_BLOCKS-1:0] prog_blocks,
  output logic [15:0]           timing_rd,
  output logic [15:0]           status_rd,
  output logic                  hv_status,
  output logic                  seq_err,
  output logic [NUM_BLOCKS-1:0] erased_mask
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic prot_q, mode_q, setup_q;
  logic field_wr, en_set_req, en_clr_req;
  logic ehv_q, hv_q, err_q, start, run, mark, last;
  seq_state_t state;

  ers_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ehv_q(ehv_q), .pre_q(pre_q), .cnt_q(cnt_q),
    .sel_q(sel_q), .prot_q(prot_q), .mode_q(mode_q), .setup_q(setup_q),
    .field_wr(field_wr), .en_set_req(en_set_req), .en_clr_req(en_clr_req),
    .timing_rd(timing_rd)
  );

  ers_fsm u_fsm (
    .clk(clk), .rst(rst), .array_wr(array_wr), .field_wr(field_wr),
    .en_set_req(en_set_req), .en_clr_req(en_clr_req), .prot_q(prot_q),
    .mode_q(mode_q), .setup_q(setup_q), .last(last), .state(state),
    .ehv_q(ehv_q), .hv_q(hv_q), .err_q(err_q), .start(start), .run(run),
    .mark(mark)
  );

  ers_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(start), .run(run), .pre_in(pre_q),
    .cnt_in(cnt_q), .last(last)
  );

  ers_blockmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk(clk), .rst(rst), .latch(start), .mark(mark), .busy(ehv_q),
    .sel_q(sel_q), .prot_q(prot_q), .mode_q(mode_q),
    .gen_en(erase_en_global), .blk0_en(blk0_en), .prog_wr(prog_wr),
    .prog_blocks(prog_blocks), .erased_q(erased_mask)
  );

  assign status_rd = {4'b0000, ehv_q, setup_q, mode_q, prot_q, sel_q};
  assign hv_status = hv_q;
  assign seq_err   = err_q;

  initial begin
    blocks_range_chk: assert (NUM_BLOCKS >= 1 && NUM_BLOCKS <= SEL_W);
  end
endmodule

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;
  localparam int NB = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_sel = 1'b0, array_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic gen_en = 1'b1, b0_en = 1'b1, prog_wr = 1'b0;
  logic [NB-1:0] prog_blocks = '0;
  logic [15:0] timing_rd, status_rd;
  logic hv_status, seq_err;
  logic [NB-1:0] erased_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [NB-1:0] exp_mask = '0;

  always #4 clk = ~clk;

  flash_erase_seq #(.NUM_BLOCKS(NB)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .array_wr(array_wr), .erase_en_global(gen_en),
    .blk0_en(b0_en), .prog_wr(prog_wr), .prog_blocks(prog_blocks),
    .timing_rd(timing_rd), .status_rd(status_rd), .hv_status(hv_status),
    .seq_err(seq_err), .erased_mask(erased_mask)
  );

  function automatic logic [15:0] stat_word(logic [7:0] sel, logic prot,
                                            logic mode, logic setup, logic en);
    return {4'b0, en, setup, mode, prot, sel};
  endfunction

  function automatic logic [NB-1:0] gated(logic [7:0] sel, logic g, logic b0);
    logic [NB-1:0] m;
    m = sel[NB-1:0];
    if (!g) m = '0;
    if (!b0) m[0] = 1'b0;
    return m;
  endfunction

  function automatic int pulse_len(int pre, int cnt);
    return (pre + 1) * (cnt + 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic sel, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic interlock();
    @(negedge clk);
    array_wr = 1'b1;
    @(negedge clk);
    array_wr = 1'b0;
  endtask

  task automatic arm(logic [7:0] sel, int pre, int cnt);
    wr_reg(1'b1, stat_word(8'h00, 1'b0, 1'b0, 1'b0, 1'b0));
    wr_reg(1'b0, {cnt[7:0], pre[7:0]});
    wr_reg(1'b1, stat_word(sel, 1'b0, 1'b1, 1'b1, 1'b0));
    interlock();
  endtask

  task automatic fire(output int len);
    wr_reg(1'b1, 16'h0800);
    @(negedge clk);
    len = 0;
    while (hv_status && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic drop_en();
    wr_reg(1'b1, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 status", status_rd, 16'h0100);
    check("R1 timing", timing_rd, 16'h0000);
    check("R1 hv", hv_status, 0);
    check("R1 err", seq_err, 0);
    check("R1 mask", erased_mask, 0);

    // R2 enable without interlock
    wr_reg(1'b1, stat_word(8'h03, 1'b0, 1'b1, 1'b1, 1'b0));
    wr_reg(1'b1, 16'h0800);
    @(negedge clk);
    check("R2 no pulse", hv_status, 0);
    check("R2 err set", seq_err, 1);
    check("R2 en not stored", status_rd[11], 0);

    // R2 interlock while protected is ignored
    wr_reg(1'b1, stat_word(8'h03, 1'b1, 1'b1, 1'b1, 1'b0));
    interlock();
    wr_reg(1'b1, 16'h0800);
    @(negedge clk);
    check("R2 protected no pulse", hv_status, 0);
    check("R2 protected mask", erased_mask, 0);
    check("R2 protected err", seq_err, 1);

    // R2 accepted interlock clears err; R3/R4 basic pulse
    arm(8'h05, 2, 3);
    check("R2 err cleared", seq_err, 0);
    check("R2 timing fields", timing_rd, 16'h0302);
    fire(len);
    check("R3 pulse length", len, pulse_len(2, 3));
    exp_mask |= gated(8'h05, 1'b1, 1'b1);
    check("R4 mask", erased_mask, exp_mask);
    check("R8 en still set", status_rd[11], 1);
    drop_en();
    check("R8 en cleared", status_rd[11], 0);

    // R8 re-enable needs a new interlock
    wr_reg(1'b1, 16'h0800);
    @(negedge clk);
    check("R8 no pulse without interlock", hv_status, 0);
    check("R8 err", seq_err, 1);

    // R11 out-of-range select bits
    prog_blocks = '1;
    @(negedge clk); prog_wr = 1'b1; @(negedge clk); prog_wr = 1'b0;
    exp_mask = '0;
    check("R10 program clears idle", erased_mask, 0);
    arm(8'hC0, 0, 0);
    fire(len);
    check("R3 min pulse", len, 1);
    check("R11 high bits ignored", erased_mask, 0);
    drop_en();
    arm(8'hFF, 0, 1);
    fire(len);
    exp_mask = '1;
    check("R11 all blocks", erased_mask, exp_mask);
    drop_en();

    // R6 block 0 gated
    prog_blocks = '1;
    @(negedge clk); prog_wr = 1'b1; @(negedge clk); prog_wr = 1'b0;
    exp_mask = '0;
    b0_en = 1'b0;
    arm(8'h03, 1, 1);
    fire(len);
    check("R6 blk0 gated", erased_mask, 6'h02);
    exp_mask = 6'h02;
    drop_en();
    b0_en = 1'b1;

    // R5 global gate
    gen_en = 1'b0;
    arm(8'h3C, 1, 2);
    fire(len);
    check("R5 pulse still runs", len, pulse_len(1, 2));
    check("R5 nothing marked", erased_mask, exp_mask);
    drop_en();
    gen_en = 1'b1;

    // R7 lock and R10 program ignored while busy
    arm(8'h04, 3, 5);
    wr_reg(1'b1, 16'h0800);
    @(negedge clk);
    check("R3 hv high", hv_status, 1);
    wr_reg(1'b1, 16'h0800 | 16'h0139);
    wr_reg(1'b0, 16'h0707);
    check("R7 status locked", status_rd, stat_word(8'h04, 1'b0, 1'b1, 1'b1, 1'b1));
    check("R7 timing locked", timing_rd, 16'h0503);
    prog_blocks = 6'h02;
    @(negedge clk); prog_wr = 1'b1; @(negedge clk); prog_wr = 1'b0;
    check("R10 program ignored busy", erased_mask, exp_mask);
    len = 0;
    while (hv_status && len < 5000) begin len++; @(negedge clk); end
    exp_mask |= 6'h04;
    check("R4 mark after locked pulse", erased_mask, exp_mask);
    drop_en();

    // R9 abort mid-pulse
    arm(8'h30, 3, 5);
    wr_reg(1'b1, 16'h0800);
    repeat (3) @(negedge clk);
    check("R9 hv during", hv_status, 1);
    drop_en();
    check("R9 hv dropped", hv_status, 0);
    repeat (30) @(negedge clk);
    check("R9 nothing marked", erased_mask, exp_mask);
    check("R9 stays low", hv_status, 0);

    // R12 field write disarms
    arm(8'h08, 0, 0);
    wr_reg(1'b1, stat_word(8'h08, 1'b0, 1'b1, 1'b1, 1'b0));
    wr_reg(1'b1, 16'h0800);
    @(negedge clk);
    check("R12 no pulse", hv_status, 0);
    check("R12 err", seq_err, 1);
    check("R12 mask", erased_mask, exp_mask);

    // random sequences: R3 R4 R5 R6 R11
    for (int i = 0; i < 40; i++) begin
      logic [7:0] sel;
      int pre, cnt;
      sel = 8'($urandom);
      pre = $urandom % 4;
      cnt = $urandom % 5;
      if ($urandom % 3 == 0) begin
        prog_blocks = NB'($urandom);
        @(negedge clk); prog_wr = 1'b1; @(negedge clk); prog_wr = 1'b0;
        exp_mask &= ~prog_blocks;
        check("R10 random program", erased_mask, exp_mask);
      end
      gen_en = ($urandom % 4) != 0;
      b0_en  = ($urandom % 2) != 0;
      arm(sel, pre, cnt);
      fire(len);
      check("R3 random length", len, pulse_len(pre, cnt));
      exp_mask |= gated(sel, gen_en, b0_en);
      check("R4 random mask", erased_mask, exp_mask);
      drop_en();
      check("R8 random idle", status_rd[11], 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule